// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Controller

This block is a single-channel asynchronous serial transmitter and receiver that software drives through four small registers. A control register picks the character size (7 or 8 data bits), optional parity (even or odd), one or two stop bits, and module enable. A divisor register sets the bit rate. A transmit-hold register launches one character. A receive-hold register returns the last received character. The control register's read view also carries three status bits: module running, transmitter empty and receive-hold full.

Seven single-cycle event pulses go out to an interrupt controller elsewhere in the chip: character received, transmitter empty, receive overrun, transmit overrun, framing error, parity error and line break. Software can send a break through a flag in the transmit-hold register. A separate control bit clamps the serial output low, whatever the transmitter is doing.

Register map (`addr`): 0 = control/status, 1 = divisor, 2 = transmit hold, 3 = receive hold. The receiver samples each bit at mid-bit using 16 ticks per bit. The character size, parity and stop settings should only be changed while both directions are idle.

Top module: `uart_regctl`

## Requirements
- R1: With divisor value D written at address 1, every transmitted bit lasts exactly 16×(D+1) clock cycles.
- R2: A frame is a low start bit, then the data bits LSB first, then an optional parity bit, then the stop bits, which are high. Control bit 1 set selects 7 data bits and clear selects 8. Control bit 2 enables parity. Control bit 3 set selects even parity and clear selects odd. Control bit 4 set selects two stop bits and clear selects one.
- R3: Control bit 0 is the enable. Status bit 8 (address 0) rises the cycle after enable is set and falls the cycle after it is cleared. While the module is off, writes to transmit hold send nothing and status bit 9 reads 0.
- R4: Status bit 9 (empty) is high while the module is on and the transmitter is idle. Writing address 2 with bit 8 clear launches wdata[7:0], masked to the character size. A transmit-empty pulse follows the end of the last stop bit.
- R5: A transmit-hold write with bit 8 clear while not empty raises the transmit-overrun pulse, and that character is never sent.
- R6: A received character goes into address 3 bits [7:0], with bit 7 zero in 7-bit mode. It sets status bit 10 (receive full) and raises the receive pulse. Reading address 3 clears bit 10.
- R7: A character that completes while bit 10 is still set raises the receive-overrun pulse and is discarded. The held character is kept.
- R8: A parity mismatch raises the parity-error pulse, and the character is still stored.
- R9: A low stop bit with nonzero data raises the framing-error pulse. The character is not stored, and the receiver waits for the line to return high.
- R10: A frame whose data and parity bits are all zero and whose stop bit is low raises the break pulse, not the framing pulse, and stores nothing.
- R11: A start bit that is no longer low at its midpoint is rejected, with no event and no stored character.
- R12: Writing address 2 with bit 8 set drives `txd` low and launches nothing. The next write with bit 8 clear releases the line and sends its data.
- R13: While control bit 5 is set, `txd` is held low whatever the transmitter is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on address 3) |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| evt_rx | output | 1 | Character received pulse |
| evt_txe | output | 1 | Transmitter empty pulse |
| evt_rxovr | output | 1 | Receive overrun pulse |
| evt_txovr | output | 1 | Transmit overrun pulse |
| evt_frm | output | 1 | Framing error pulse |
| evt_par | output | 1 | Parity error pulse |
| evt_brk | output | 1 | Break detected pulse |

## Verification
Random frame settings and characters are run both ways, each checked for data, parity, stop-bit count and total frame length. A design that miscounted the second stop bit or ran the parity sense backwards would fail the length or parity checks. Directed cases cover the following:
- Two transmit writes back to back: a design that failed to drop the second write would send two characters.
- Two received characters with no read between them: a design that failed to discard the second would overwrite the held character.
- A low stop bit after nonzero data, and a low stop bit after all-zero data: a design that confused framing error with break would raise the wrong pulse.
- A short low glitch: a design without the midpoint start check would report a bogus character.
- The forced-low and break paths, and an exact bit-length measurement at a second divisor value, to catch off-by-one errors in the divisor.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_TXH  = 2'd2;
    localparam logic [1:0] A_RXH  = 2'd3;

    localparam int CTRL_W  = 6;
    localparam int C_EN    = 0;
    localparam int C_CH7   = 1;
    localparam int C_PEN   = 2;
    localparam int C_PEVEN = 3;
    localparam int C_STOP2 = 4;
    localparam int C_TXLOW = 5;

    localparam int S_ON     = 8;
    localparam int S_EMPTY  = 9;
    localparam int S_RXFULL = 10;
    localparam int TXH_BRK  = 8;

    // F_HOLD: transmitter armed and waiting for a tick; receiver waiting for the line to go high
    typedef enum logic [2:0] {F_IDLE, F_START, F_DATA, F_PAR, F_STOP, F_HOLD} fr_st_e;
endpackage

// File: rtl/uart_regctl_baud.sv
module uart_regctl_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } bd_s;

    bd_s q, n;

    always_comb begin
        n = q;
        n.tick = 1'b0;
        if (!run) begin
            n.cnt = '0;
        end else if (q.cnt >= div) begin
            n.cnt  = '0;
            n.tick = 1'b1;
        end else begin
            n.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign tick = q.tick;
endmodule

// File: rtl/uart_regctl_tx.sv
module uart_regctl_tx
    import uart_regctl_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       ch7,
    input  logic       pen,
    input  logic       peven,
    input  logic       stop2,
    input  logic       launch,
    input  logic [7:0] din,
    output logic       busy,
    output logic       line,
    output logic       done
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    typedef struct packed {
        fr_st_e           st;
        logic [SUB_W-1:0] sub;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic             par;
        logic             done;
    } tx_s;

    tx_s        q, n;
    logic [7:0] masked;
    logic [2:0] last_idx;
    logic       bit_end;

    always_comb begin
        masked   = ch7 ? {1'b0, din[6:0]} : din;
        last_idx = ch7 ? 3'd6 : 3'd7;
        bit_end  = tick && (q.sub == SUB_LAST);
        n        = q;
        n.done   = 1'b0;
        if (tick && q.st != F_IDLE && q.st != F_HOLD)
            n.sub = bit_end ? '0 : q.sub + 1'b1;
        case (q.st)
            F_IDLE: if (launch) begin
                n.st  = F_HOLD;
                n.sh  = masked;
                n.par = peven ? ^masked : ~^masked;
            end
            F_HOLD: if (tick) begin
                n.st  = F_START;
                n.sub = '0;
            end
            F_START: if (bit_end) begin
                n.st   = F_DATA;
                n.bitn = '0;
            end
            F_DATA: if (bit_end) begin
                n.sh = q.sh >> 1;
                if (q.bitn == last_idx) begin
                    n.st   = pen ? F_PAR : F_STOP;
                    n.bitn = '0;
                end else begin
                    n.bitn = q.bitn + 1'b1;
                end
            end
            F_PAR: if (bit_end) begin
                n.st   = F_STOP;
                n.bitn = '0;
            end
            F_STOP: if (bit_end) begin
                if (stop2 && q.bitn == 3'd0) begin
                    n.bitn = 3'd1;
                end else begin
                    n.st   = F_IDLE;
                    n.done = 1'b1;
                end
            end
            default: n.st = F_IDLE;
        endcase
        if (!run) begin
            n.st  = F_IDLE;
            n.sub = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: F_IDLE, default: '0};
        else        q <= n;
    end

    always_comb begin
        case (q.st)
            F_START: line = 1'b0;
            F_DATA:  line = q.sh[0];
            F_PAR:   line = q.par;
            default: line = 1'b1;
        endcase
    end

    assign busy = (q.st != F_IDLE);
    assign done = q.done;
endmodule

// File: rtl/uart_regctl_rx.sv
module uart_regctl_rx
    import uart_regctl_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       rxd,
    input  logic       ch7,
    input  logic       pen,
    input  logic       peven,
    input  logic       stop2,
    output logic [7:0] dout,
    output logic       got,
    output logic       perr,
    output logic       ferr,
    output logic       brk
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

    typedef struct packed {
        fr_st_e           st;
        logic [SUB_W-1:0] sub;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic             pbit;
        logic             got;
        logic             perr;
        logic             ferr;
        logic             brk;
    } rx_s;

    rx_s        q, n;
    logic [7:0] data;
    logic [2:0] last_idx;
    logic       par_ref;
    logic       bit_end;

    always_comb begin
        data     = ch7 ? {1'b0, q.sh[7:1]} : q.sh;
        last_idx = ch7 ? 3'd6 : 3'd7;
        par_ref  = peven ? ^data : ~^data;
        bit_end  = tick && (q.sub == SUB_LAST);
        n        = q;
        n.got    = 1'b0;
        n.perr   = 1'b0;
        n.ferr   = 1'b0;
        n.brk    = 1'b0;
        if (tick && q.st != F_IDLE && q.st != F_HOLD)
            n.sub = bit_end ? '0 : q.sub + 1'b1;
        case (q.st)
            F_IDLE: if (tick && !rxd) begin
                n.st  = F_START;
                n.sub = '0;
            end
            F_START: if (tick && q.sub == SUB_MID) begin
                n.sub = '0;
                if (rxd) begin
                    n.st = F_IDLE;
                end else begin
                    n.st   = F_DATA;
                    n.bitn = '0;
                end
            end
            F_DATA: if (bit_end) begin
                n.sh = {rxd, q.sh[7:1]};
                if (q.bitn == last_idx) begin
                    n.st   = pen ? F_PAR : F_STOP;
                    n.bitn = '0;
                end else begin
                    n.bitn = q.bitn + 1'b1;
                end
            end
            F_PAR: if (bit_end) begin
                n.pbit = rxd;
                n.st   = F_STOP;
            end
            F_STOP: if (bit_end) begin
                if (!rxd) begin
                    n.st = F_HOLD;
                    if (data == 8'd0 && !(pen && q.pbit)) n.brk  = 1'b1;
                    else                                   n.ferr = 1'b1;
                end else if (stop2 && q.bitn == 3'd0) begin
                    n.bitn = 3'd1;
                end else begin
                    n.st   = F_IDLE;
                    n.got  = 1'b1;
                    n.perr = pen && (q.pbit != par_ref);
                end
            end
            F_HOLD: if (rxd) n.st = F_IDLE;
            default: n.st = F_IDLE;
        endcase
        if (!run) begin
            n.st  = F_IDLE;
            n.sub = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: F_IDLE, default: '0};
        else        q <= n;
    end

    assign dout = data;
    assign got  = q.got;
    assign perr = q.perr;
    assign ferr = q.ferr;
    assign brk  = q.brk;
endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
    import uart_regctl_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             rxd,
    output logic             txd,
    output logic             evt_rx,
    output logic             evt_txe,
    output logic             evt_rxovr,
    output logic             evt_txovr,
    output logic             evt_frm,
    output logic             evt_par,
    output logic             evt_brk
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DIV_W-1:0]  div;
        logic              brk;
        logic              on;
        logic              rxfull;
        logic [7:0]        rxhold;
        logic [1:0]        sy;
        logic              e_rx, e_txe, e_rxo, e_txo, e_frm, e_par, e_brk;
    } top_s;

    top_s       q, n;
    logic       tick, tx_busy, tx_line, tx_done, tx_wr, launch, empty;
    logic       rx_got, rx_perr, rx_ferr, rx_brk;
    logic [7:0] rx_dout;
    logic       en_bit, txlow_bit;

    uart_regctl_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(q.on), .div(q.div), .tick(tick)
    );

    uart_regctl_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(q.on), .tick(tick),
        .ch7(q.ctrl[C_CH7]), .pen(q.ctrl[C_PEN]), .peven(q.ctrl[C_PEVEN]),
        .stop2(q.ctrl[C_STOP2]), .launch(launch), .din(wdata[7:0]),
        .busy(tx_busy), .line(tx_line), .done(tx_done)
    );

    uart_regctl_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(q.on), .tick(tick), .rxd(q.sy[1]),
        .ch7(q.ctrl[C_CH7]), .pen(q.ctrl[C_PEN]), .peven(q.ctrl[C_PEVEN]),
        .stop2(q.ctrl[C_STOP2]), .dout(rx_dout), .got(rx_got),
        .perr(rx_perr), .ferr(rx_ferr), .brk(rx_brk)
    );

    always_comb begin
        tx_wr  = wr_en && (addr == A_TXH);
        launch = tx_wr && !wdata[TXH_BRK] && q.on && !tx_busy;
        empty  = q.on && !tx_busy;
        n       = q;
        n.sy    = {q.sy[0], rxd};
        n.on    = q.ctrl[C_EN];
        n.e_rx  = 1'b0;
        n.e_rxo = 1'b0;
        n.e_txo = tx_wr && !wdata[TXH_BRK] && q.on && tx_busy;
        n.e_txe = tx_done;
        n.e_frm = rx_ferr;
        n.e_brk = rx_brk;
        n.e_par = rx_perr && !q.rxfull;
        if (wr_en && addr == A_CTRL) n.ctrl = wdata[CTRL_W-1:0];
        if (wr_en && addr == A_DIV)  n.div  = wdata[DIV_W-1:0];
        if (tx_wr)                   n.brk  = wdata[TXH_BRK];
        if (rd_en && addr == A_RXH)  n.rxfull = 1'b0;
        if (rx_got) begin
            if (q.rxfull) begin
                n.e_rxo = 1'b1;
            end else begin
                n.rxfull = 1'b1;
                n.rxhold = rx_dout;
                n.e_rx   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sy: 2'b11, default: '0};
        else        q <= n;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTRL_W-1:0] = q.ctrl;
                rdata[S_ON]       = q.on;
                rdata[S_EMPTY]    = empty;
                rdata[S_RXFULL]   = q.rxfull;
            end
            A_DIV:   rdata[DIV_W-1:0] = q.div;
            A_TXH:   rdata[TXH_BRK]   = q.brk;
            default: rdata[7:0]       = q.rxhold;
        endcase
    end

    assign txd       = (q.ctrl[C_TXLOW] || q.brk) ? 1'b0 : tx_line;
    assign en_bit    = q.ctrl[C_EN];
    assign txlow_bit = q.ctrl[C_TXLOW];
    assign evt_rx    = q.e_rx;
    assign evt_txe   = q.e_txe;
    assign evt_rxovr = q.e_rxo;
    assign evt_txovr = q.e_txo;
    assign evt_frm   = q.e_frm;
    assign evt_par   = q.e_par;
    assign evt_brk   = q.e_brk;
endmodule

// File: rtl/uart_regctl_chk.sv
module uart_regctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_bit,
    input logic       on_st,
    input logic       txlow_bit,
    input logic       brk_st,
    input logic       txd,
    input logic       launch,
    input logic       empty_st,
    input logic [7:0] rxhold,
    input logic       evt_rx,
    input logic       evt_rxovr,
    input logic       evt_frm,
    input logic       evt_brk
);
    // R3
    on_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) en_bit |=> on_st);
    // R3
    off_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_bit |=> !on_st);
    // R13
    txlow_chk: assert property (@(posedge clk) disable iff (!rst_n) txlow_bit |-> !txd);
    // R12
    brk_line_chk: assert property (@(posedge clk) disable iff (!rst_n) brk_st |-> !txd);
    // R4
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) launch |=> !empty_st);
    // R7
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) evt_rxovr |-> $stable(rxhold));
    // R9 R10
    rx_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_rx, evt_rxovr, evt_frm, evt_brk}));
endmodule

bind uart_regctl uart_regctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_bit(en_bit), .on_st(q.on),
    .txlow_bit(txlow_bit), .brk_st(q.brk), .txd(txd), .launch(launch),
    .empty_st(empty), .rxhold(q.rxhold), .evt_rx(evt_rx),
    .evt_rxovr(evt_rxovr), .evt_frm(evt_frm), .evt_brk(evt_brk)
);

// File: tb/sim_uart_regctl.sv
module sim_uart_regctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        txd, evt_rx, evt_txe, evt_rxovr, evt_txovr, evt_frm, evt_par, evt_brk;

    always #4 clk = ~clk;

    uart_regctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .evt_rx(evt_rx),
        .evt_txe(evt_txe), .evt_rxovr(evt_rxovr), .evt_txovr(evt_txovr),
        .evt_frm(evt_frm), .evt_par(evt_par), .evt_brk(evt_brk)
    );

    int errs = 0, checks = 0, bl = 32, cyc = 0;
    int n_rx = 0, n_txe = 0, n_rxo = 0, n_txo = 0, n_frm = 0, n_par = 0, n_brk = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (evt_rx)    n_rx  <= n_rx + 1;
        if (evt_txe)   n_txe <= n_txe + 1;
        if (evt_rxovr) n_rxo <= n_rxo + 1;
        if (evt_txovr) n_txo <= n_txo + 1;
        if (evt_frm)   n_frm <= n_frm + 1;
        if (evt_par)   n_par <= n_par + 1;
        if (evt_brk)   n_brk <= n_brk + 1;
    end

    task automatic check(string req, string what, int act, int expv);
        checks++;
        if (act !== expv) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic wr(logic [1:0] a, int d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = 16'(d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, bit side, output int v);
        @(negedge clk); addr = a; rd_en = side; #1 v = int'(rdata);
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic int mask(int d, bit c7);
        return c7 ? (d & 8'h7f) : (d & 8'hff);
    endfunction

    function automatic int par_of(int d, bit c7, bit even);
        logic [7:0] m = 8'(mask(d, c7));
        return even ? int'(^m) : int'(~^m);
    endfunction

    task automatic drive_bit(bit b);
        rxd = b; repeat (bl) @(negedge clk);
    endtask

    task automatic send_frame(int d, bit c7, bit pen, bit peven, bit st2, bit bad, bit stop_low);
        int m = mask(d, c7);
        drive_bit(1'b0);
        for (int i = 0; i < (c7 ? 7 : 8); i++) drive_bit(m[i]);
        if (pen) drive_bit(1'(par_of(d, c7, peven)) ^ bad);
        if (stop_low) begin drive_bit(1'b0); drive_bit(1'b0); end
        else begin drive_bit(1'b1); if (st2) drive_bit(1'b1); end
        rxd = 1'b1;
        repeat (2 * bl) @(negedge clk);
    endtask

    task automatic recv_frame(bit c7, bit pen, bit st2, output int d, output int p,
                              output int stp, output int dur);
        int k = 0, t0, base = n_txe;
        d = 0; p = 0; stp = 1; dur = -1;
        while (txd !== 1'b0 && k < 4000) begin @(negedge clk); k++; end
        if (k >= 4000) begin d = -1; return; end
        t0 = cyc;
        repeat (bl / 2) @(negedge clk);
        if (txd !== 1'b0) stp = 0;
        for (int i = 0; i < (c7 ? 7 : 8); i++) begin
            repeat (bl) @(negedge clk);
            if (txd) d |= (1 << i);
        end
        if (pen) begin repeat (bl) @(negedge clk); p = int'(txd); end
        repeat (bl) @(negedge clk);
        if (txd !== 1'b1) stp = 0;
        if (st2) begin repeat (bl) @(negedge clk); if (txd !== 1'b1) stp = 0; end
        k = 0;
        while (n_txe == base && k < 4000) begin @(negedge clk); k++; end
        dur = cyc - t0;
    endtask

    task automatic count_low(int n, output int c);
        c = 0;
        repeat (n) begin @(negedge clk); if (!txd) c++; end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int v, d, p, stp, dur, c, base, base2, bits, exp_len;
        bit c7, pen, peven, st2, bad;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        rd(2'd0, 0, v);
        check("R3", "reset ctrl/status", v, 0);
        check("R3", "reset txd", int'(txd), 1);

        // R3: transmit write while off sends nothing
        wr(2'd1, 1);
        wr(2'd2, 8'h55);
        count_low(400, c);
        check("R3", "tx while off", c, 0);
        rd(2'd0, 0, v);
        check("R3", "empty while off", (v >> 9) & 1, 0);

        wr(2'd0, 1);
        rd(2'd0, 0, v);
        check("R3", "on bit after enable", (v >> 8) & 1, 1);
        check("R4", "empty when idle", (v >> 9) & 1, 1);

        // random traffic in both directions (R2 R4 R6 R8)
        for (int it = 0; it < 16; it++) begin
            c7 = 1'($urandom); pen = 1'($urandom); peven = 1'($urandom); st2 = 1'($urandom);
            wr(2'd0, 1 | (c7 << 1) | (pen << 2) | (peven << 3) | (st2 << 4));
            v = int'($urandom % 256);
            wr(2'd2, v);
            recv_frame(c7, pen, st2, d, p, stp, dur);
            check("R2", "tx data", d, mask(v, c7));
            if (pen) check("R2", "tx parity", p, par_of(v, c7, peven));
            check("R2", "tx stop bits", stp, 1);
            bits = 1 + (c7 ? 7 : 8) + pen + 1 + st2;
            exp_len = bits * bl + 2;
            check("R4", "frame length to empty pulse", int'(dur >= exp_len - 2 && dur <= exp_len + 2), 1);

            v = int'($urandom % 256);
            bad = pen && ($urandom % 3 == 0);
            base = n_par;
            send_frame(v, c7, pen, peven, st2, bad, 1'b0);
            rd(2'd0, 0, d);
            check("R6", "rx full set", (d >> 10) & 1, 1);
            rd(2'd3, 1, d);
            check("R6", "rx data", d, mask(v, c7));
            check("R8", "parity error pulses", n_par - base, int'(bad));
            rd(2'd0, 0, d);
            check("R6", "rx full cleared by read", (d >> 10) & 1, 0);
        end

        wr(2'd0, 1);
        // R5: second write while busy is dropped
        base = n_txo; base2 = n_txe;
        wr(2'd2, 8'h3C);
        wr(2'd2, 8'h99);
        recv_frame(0, 0, 0, d, p, stp, dur);
        check("R5", "first char sent", d, 8'h3C);
        check("R5", "overrun pulse", n_txo - base, 1);
        count_low(12 * bl, c);
        check("R5", "dropped char not sent", c, 0);
        check("R5", "one empty pulse", n_txe - base2, 1);

        // R7: second character while full
        base = n_rxo;
        send_frame(8'h11, 0, 0, 0, 0, 0, 0);
        send_frame(8'h22, 0, 0, 0, 0, 0, 0);
        check("R7", "rx overrun pulse", n_rxo - base, 1);
        rd(2'd3, 1, d);
        check("R7", "held char kept", d, 8'h11);

        // R9: framing error
        base = n_frm; base2 = n_rx;
        send_frame(8'h5A, 0, 0, 0, 0, 0, 1);
        check("R9", "framing pulse", n_frm - base, 1);
        check("R9", "no rx pulse", n_rx - base2, 0);
        rd(2'd0, 0, d);
        check("R9", "nothing stored", (d >> 10) & 1, 0);

        // R10: break
        base = n_brk; base2 = n_frm;
        send_frame(8'h00, 0, 0, 0, 0, 0, 1);
        check("R10", "break pulse", n_brk - base, 1);
        check("R10", "no framing pulse", n_frm - base2, 0);
        rd(2'd0, 0, d);
        check("R10", "nothing stored", (d >> 10) & 1, 0);

        // R11: short start glitch
        base = n_rx; base2 = n_frm + n_brk;
        @(negedge clk); rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
        repeat (20 * bl) @(negedge clk);
        check("R11", "glitch rx pulses", n_rx - base, 0);
        check("R11", "glitch error pulses", n_frm + n_brk - base2, 0);
        rd(2'd0, 0, d);
        check("R11", "glitch nothing stored", (d >> 10) & 1, 0);

        // R12: forced break via transmit hold
        wr(2'd2, 16'h100);
        count_low(3 * bl, c);
        check("R12", "break holds line low", c, 3 * bl);
        rd(2'd0, 0, d);
        check("R12", "break write launches nothing", (d >> 9) & 1, 1);
        wr(2'd2, 8'hA5);
        recv_frame(0, 0, 0, d, p, stp, dur);
        check("R12", "char after break release", d, 8'hA5);

        // R13: forced low output
        wr(2'd0, 16'h21);
        wr(2'd2, 8'hFF);
        count_low(12 * bl, c);
        check("R13", "txd forced low", c, 12 * bl);
        wr(2'd0, 1);
        repeat (2) @(negedge clk);
        check("R13", "txd released", int'(txd), 1);

        // R3: disable drops on bit
        wr(2'd0, 0);
        rd(2'd0, 0, d);
        check("R3", "on bit after disable", (d >> 8) & 1, 0);

        // R1: exact bit time at divisor 3
        wr(2'd1, 3);
        wr(2'd0, 1);
        bl = 64;
        wr(2'd2, 8'h00);
        c = 0;
        while (txd !== 1'b0 && c < 2000) begin @(negedge clk); c++; end
        c = 0;
        while (txd === 1'b0 && c < 2000) begin @(negedge clk); c++; end
        check("R1", "low run start+8 zeros", c, 9 * 64);
        repeat (4 * bl) @(negedge clk);

        finish_run();
    end
endmodule